// File: doc/BRIEF.md
# Codec Input Frame Serializer

This block sits on the codec side of an AC'97-style link. It drives the serial input data line toward the controller, one bit per bit clock. Each frame it builds, in this order:

- a 16-bit tag slot;
- twelve 20-bit slots, which carry a status address, status data, a stereo pair of ADC samples and a word of GPIO input levels.

It then shifts the whole 256-bit frame out MSB first. A frame begins when the sync input is first seen high.

Sample pairs, status responses and GPIO levels come in on parallel ports. ADC samples and status responses are held in registers until the next frame boundary. That frame takes a snapshot of them, so a request never ends up split across two frames. A two-bit control field picks which of four slot pairs carries the left and right samples.

Top module: `ac_link_in_framer`

## Requirements
- R1: After reset, `sdata_out` stays 0 until a frame is started by `sync` going high.
- R2: A frame starts on the clock edge where `sync` is 1 and was 0 at the previous edge. Frame bit k (k=0 is tag bit 15; slot n field bit 19 is frame bit 16+20*(n-1)) appears on `sdata_out` after the (k+1)-th following rising edge. After the 256th bit the line returns to 0.
- R3: When a status response is held at frame start, three things happen in that same frame. Tag bits 14 and 13 are both 1. Slot 1 carries the address in bits 19:12, with zeros below. Slot 2 carries the data in bits 19:4, with zeros below.
- R4: When no status response is held, tag bits 14 and 13 are 0, and slots 1 and 2 are all zeros.
- R5: A status request accepted after a frame has started is sent whole in the next frame. This includes a request on the frame-start edge itself. A response is sent once and then dropped. Of several requests before one frame, the last one is sent.
- R6: `slot_sel` is sampled at frame start and places the held sample pair: 0 gives slots 3/4, 1 gives 6/9, 2 gives 7/8, 3 gives 10/11. The left sample goes in the first slot of the pair. Each sample is left-justified in its slot.
- R7: When a sample pair is held, tag bit (15−s) is set for both chosen slots s. The pair is sent once, and the following frame carries no samples unless a new pair arrives.
- R8: Without a held sample pair, no ADC tag bit is set and all ADC slots are zero.
- R9: Slot 12 carries `gpio_in` (sampled at frame start) in bits 19:4, and tag bit 3 is always 1.
- R10: Tag bit 15 is the OR of tag bits 14:3, so it is always 1. Tag bits 2:0 and every unused slot are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| sync | input | 1 | Frame sync; rising level starts a frame |
| slot_sel | input | 2 | ADC slot-pair selector |
| adc_valid | input | 1 | One-cycle strobe: new sample pair |
| adc_left | input | SAMPLE_W | Left ADC sample |
| adc_right | input | SAMPLE_W | Right ADC sample |
| stat_req | input | 1 | One-cycle strobe: status response to send |
| stat_addr | input | ADDR_W | Status register address |
| stat_data | input | DATA_W | Status register data |
| gpio_in | input | GPIO_W | GPIO input levels |
| sdata_out | output | 1 | Serial input-frame data |

## Verification
The main check walks a table of frames and compares every slot of each captured frame against an independently built expected frame. The table covers:

- **Slot pairs:** all four selector values, which shows that samples land in the chosen pair and nowhere else.
- **Samples and patterns:** frames with and without a sample pair, and all-ones, single-bit and alternating patterns, which separate slot placement from bit order and justification.
- **Status responses:** frames with and without a response, including an all-zero response that can only be told apart from none by its tag bits.

Directed frames then send a status request in mid-frame and on the frame-start edge, and send two requests before a single frame. These separate "held for the next frame" from "lost" or "sent early", and "latest wins" from "first wins".

// File: rtl/ac_in_pkg.sv
package ac_in_pkg;
  localparam int SLOT_W     = 20;
  localparam int TAG_W      = 16;
  localparam int NUM_DSLOTS = 12;
  localparam int FRAME_W    = TAG_W + SLOT_W * NUM_DSLOTS;
  localparam int CNT_W      = $clog2(FRAME_W);

  typedef enum logic [1:0] {
    PAIR_3_4   = 2'd0,
    PAIR_6_9   = 2'd1,
    PAIR_7_8   = 2'd2,
    PAIR_10_11 = 2'd3
  } pair_e;

  function automatic int left_slot(pair_e p);
    case (p)
      PAIR_3_4:   return 3;
      PAIR_6_9:   return 6;
      PAIR_7_8:   return 7;
      default:    return 10;
    endcase
  endfunction

  function automatic int right_slot(pair_e p);
    case (p)
      PAIR_3_4:   return 4;
      PAIR_6_9:   return 9;
      PAIR_7_8:   return 8;
      default:    return 11;
    endcase
  endfunction
endpackage

// File: rtl/ac_in_capture.sv
module ac_in_capture #(
  parameter int SAMPLE_W = 20,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                adc_valid,
  input  logic [SAMPLE_W-1:0] adc_left,
  input  logic [SAMPLE_W-1:0] adc_right,
  input  logic                stat_req,
  input  logic [ADDR_W-1:0]   stat_addr,
  input  logic [DATA_W-1:0]   stat_data,
  output logic                adc_pend,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [SAMPLE_W-1:0] right_q,
  output logic                stat_pend,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [DATA_W-1:0]   data_q
);
  // Pending flags: a new strobe wins over the consume on the load edge,
  // so a strobe arriving at frame start waits for the following frame.
  always_ff @(posedge clk) begin
    if (rst) begin
      adc_pend  <= 1'b0;
      stat_pend <= 1'b0;
    end else begin
      if (adc_valid)   adc_pend <= 1'b1;
      else if (load)   adc_pend <= 1'b0;
      if (stat_req)    stat_pend <= 1'b1;
      else if (load)   stat_pend <= 1'b0;
    end
  end

  // Payload registers need no reset; the pending flags qualify them.
  always_ff @(posedge clk) begin
    if (adc_valid) begin
      left_q  <= adc_left;
      right_q <= adc_right;
    end
    if (stat_req) begin
      addr_q <= stat_addr;
      data_q <= stat_data;
    end
  end

  p_stat_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (stat_pend && !load && !stat_req) |=> (stat_pend && $stable(addr_q) && $stable(data_q)));
  p_stat_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (load && !stat_req) |=> !stat_pend);
  p_adc_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (load && !adc_valid) |=> !adc_pend);
endmodule

// File: rtl/ac_in_frame_build.sv
module ac_in_frame_build
  import ac_in_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int GPIO_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  pair_e               pair,
  input  logic                adc_pend,
  input  logic [SAMPLE_W-1:0] left_q,
  input  logic [SAMPLE_W-1:0] right_q,
  input  logic                stat_pend,
  input  logic [ADDR_W-1:0]   addr_q,
  input  logic [DATA_W-1:0]   data_q,
  input  logic [GPIO_W-1:0]   gpio,
  output logic [FRAME_W-1:0]  frame
);
  logic [TAG_W-1:0] tag;
  logic [7:0]       adc_tags;

  for (genvar s = 1; s <= NUM_DSLOTS; s++) begin : g_slot
    localparam int TOP = FRAME_W - 1 - TAG_W - SLOT_W * (s - 1);
    logic [SLOT_W-1:0] val;
    logic              ok;

    if (s == 1) begin : g_addr
      always_comb begin
        val = '0;
        val[SLOT_W-1 -: ADDR_W] = addr_q;
        if (!stat_pend) val = '0;
        ok = stat_pend;
      end
    end else if (s == 2) begin : g_data
      always_comb begin
        val = '0;
        val[SLOT_W-1 -: DATA_W] = data_q;
        if (!stat_pend) val = '0;
        ok = stat_pend;
      end
    end else if (s == NUM_DSLOTS) begin : g_gpio
      always_comb begin
        val = '0;
        val[SLOT_W-1 -: GPIO_W] = gpio;
        ok = 1'b1;
      end
    end else begin : g_adc
      always_comb begin
        val = '0;
        ok  = 1'b0;
        if (adc_pend && s == left_slot(pair)) begin
          val[SLOT_W-1 -: SAMPLE_W] = left_q;
          ok = 1'b1;
        end else if (adc_pend && s == right_slot(pair)) begin
          val[SLOT_W-1 -: SAMPLE_W] = right_q;
          ok = 1'b1;
        end
      end
    end

    assign frame[TOP -: SLOT_W] = val;
    assign tag[TAG_W-1-s]       = ok;
  end

  assign tag[TAG_W-1] = |tag[TAG_W-2 -: NUM_DSLOTS];
  assign tag[2:0]     = 3'b000;
  assign frame[FRAME_W-1 -: TAG_W] = tag;

  // ADC-capable slots: 3,4 (tag 12,11) and 6..11 (tag 9..4)
  assign adc_tags = {tag[12], tag[11], tag[9:4]};

  p_adc_pair_r7: assert property (@(posedge clk) disable iff (rst)
    ($countones(adc_tags) == 0) || ($countones(adc_tags) == 2));
endmodule

// File: rtl/ac_in_shifter.sv
module ac_in_shifter
  import ac_in_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sync,
  input  logic [FRAME_W-1:0] frame,
  output logic               load,
  output logic               sdata_out
);
  logic               sync_d;
  logic               busy;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sr;

  assign load = sync && !sync_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_d    <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      sdata_out <= 1'b0;
    end else begin
      sync_d <= sync;
      if (load) begin
        busy      <= 1'b1;
        cnt       <= '0;
        sdata_out <= 1'b0;
      end else if (busy) begin
        sdata_out <= sr[FRAME_W-1];
        cnt       <= cnt + 1'b1;
        if (cnt == CNT_W'(FRAME_W - 1)) busy <= 1'b0;
      end else begin
        sdata_out <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load)      sr <= frame;
    else if (busy) sr <= {sr[FRAME_W-2:0], 1'b0};
  end

  p_start_r2: assert property (@(posedge clk) disable iff (rst)
    load |=> (busy && cnt == '0 && !sdata_out));
  p_frame_len_r2: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == CNT_W'(FRAME_W - 1) && !load) |=> !busy);
endmodule

// File: rtl/ac_link_in_framer.sv
module ac_link_in_framer
  import ac_in_pkg::*;
#(
  parameter int SAMPLE_W = 20,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int GPIO_W   = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sync,
  input  logic [1:0]          slot_sel,
  input  logic                adc_valid,
  input  logic [SAMPLE_W-1:0] adc_left,
  input  logic [SAMPLE_W-1:0] adc_right,
  input  logic                stat_req,
  input  logic [ADDR_W-1:0]   stat_addr,
  input  logic [DATA_W-1:0]   stat_data,
  input  logic [GPIO_W-1:0]   gpio_in,
  output logic                sdata_out
);
  logic                load;
  logic                adc_pend, stat_pend;
  logic [SAMPLE_W-1:0] left_q, right_q;
  logic [ADDR_W-1:0]   addr_q;
  logic [DATA_W-1:0]   data_q;
  logic [FRAME_W-1:0]  frame;

  u_capture_width_check: assert final (SAMPLE_W <= SLOT_W && ADDR_W <= SLOT_W &&
                                       DATA_W <= SLOT_W && GPIO_W <= SLOT_W);

  ac_in_capture #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_capture (
    .clk(clk), .rst(rst), .load(load),
    .adc_valid(adc_valid), .adc_left(adc_left), .adc_right(adc_right),
    .stat_req(stat_req), .stat_addr(stat_addr), .stat_data(stat_data),
    .adc_pend(adc_pend), .left_q(left_q), .right_q(right_q),
    .stat_pend(stat_pend), .addr_q(addr_q), .data_q(data_q)
  );

  ac_in_frame_build #(.SAMPLE_W(SAMPLE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
                      .GPIO_W(GPIO_W)) u_build (
    .clk(clk), .rst(rst), .pair(pair_e'(slot_sel)),
    .adc_pend(adc_pend), .left_q(left_q), .right_q(right_q),
    .stat_pend(stat_pend), .addr_q(addr_q), .data_q(data_q),
    .gpio(gpio_in), .frame(frame)
  );

  ac_in_shifter u_shift (
    .clk(clk), .rst(rst), .sync(sync), .frame(frame),
    .load(load), .sdata_out(sdata_out)
  );
endmodule

// File: tb/tb_ac_link_in_framer.sv
`timescale 1ns/1ps
module tb_ac_link_in_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sync = 1'b0;
  logic [1:0]  slot_sel = 2'd0;
  logic        adc_valid = 1'b0;
  logic [19:0] adc_left = '0, adc_right = '0;
  logic        stat_req = 1'b0;
  logic [7:0]  stat_addr = '0;
  logic [15:0] stat_data = '0;
  logic [15:0] gpio_in = '0;
  logic        sdata_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  ac_link_in_framer dut (
    .clk(clk), .rst(rst), .sync(sync), .slot_sel(slot_sel),
    .adc_valid(adc_valid), .adc_left(adc_left), .adc_right(adc_right),
    .stat_req(stat_req), .stat_addr(stat_addr), .stat_data(stat_data),
    .gpio_in(gpio_in), .sdata_out(sdata_out)
  );

  localparam int NV = 6;
  localparam logic [1:0]  V_SEL  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd1};
  localparam logic        V_AVAL [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [19:0] V_L    [NV] = '{20'hABCDE, 20'hFFFFF, 20'h80000, 20'h5A5A5, 20'h11111, 20'h22222};
  localparam logic [19:0] V_R    [NV] = '{20'h12345, 20'h00001, 20'h7FFFF, 20'hA5A5A, 20'h33333, 20'h44444};
  localparam logic        V_SREQ [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic [7:0]  V_ADDR [NV] = '{8'h26, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00};
  localparam logic [15:0] V_DATA [NV] = '{16'h800F, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000};
  localparam logic [15:0] V_GPIO [NV] = '{16'h0001, 16'hFFFF, 16'h0000, 16'h8000, 16'h1234, 16'h00F0};

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [19:0] field(input logic [255:0] f, input int s);
    if (s == 0) return {4'h0, f[255:240]};
    return f[(239 - 20 * (s - 1)) -: 20];
  endfunction

  function automatic logic [255:0] build_exp(input logic [1:0] sel, input logic av,
      input logic [19:0] l, input logic [19:0] r, input logic sq,
      input logic [7:0] a, input logic [15:0] d, input logic [15:0] g);
    logic [255:0] e;
    logic [15:0]  t;
    int ls, rs;
    e = '0; t = '0;
    case (sel)
      2'd0: begin ls = 3;  rs = 4;  end
      2'd1: begin ls = 6;  rs = 9;  end
      2'd2: begin ls = 7;  rs = 8;  end
      default: begin ls = 10; rs = 11; end
    endcase
    if (sq) begin
      e[239 -: 20] = {a, 12'h000};
      e[219 -: 20] = {d, 4'h0};
      t[14] = 1'b1; t[13] = 1'b1;
    end
    if (av) begin
      e[(239 - 20 * (ls - 1)) -: 20] = l;
      e[(239 - 20 * (rs - 1)) -: 20] = r;
      t[15 - ls] = 1'b1; t[15 - rs] = 1'b1;
    end
    e[19:0] = {g, 4'h0};
    t[3]  = 1'b1;
    t[15] = 1'b1;
    e[255:240] = t;
    return e;
  endfunction

  task automatic compare(input string ctx, input logic [255:0] got, input logic [255:0] exp,
                         input logic [1:0] sel, input logic av);
    for (int s = 0; s <= 12; s++) begin
      string req;
      if (s == 0)                    req = "R10 tag";
      else if (s <= 2)               req = "R3/R4 status";
      else if (s == 12)              req = "R9 gpio";
      else if (!av)                  req = "R8 no-sample";
      else                           req = "R6/R7 adc";
      check($sformatf("%s %s slot%0d sel%0d", ctx, req, s, sel), {12'h0, field(got, s)},
            {12'h0, field(exp, s)});
    end
  endtask

  task automatic send_adc(input logic [19:0] l, input logic [19:0] r);
    @(negedge clk); adc_left = l; adc_right = r; adc_valid = 1'b1;
    @(negedge clk); adc_valid = 1'b0;
  endtask

  task automatic send_stat(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); stat_addr = a; stat_data = d; stat_req = 1'b1;
    @(negedge clk); stat_req = 1'b0;
  endtask

  // inj: -1 none, -2 on the frame-start edge, k >= 0 after frame bit k
  task automatic run_frame(input int inj, input logic [7:0] ia, input logic [15:0] id,
                           output logic [255:0] got);
    @(negedge clk);
    sync = 1'b1;
    if (inj == -2) begin stat_addr = ia; stat_data = id; stat_req = 1'b1; end
    @(negedge clk);
    stat_req = 1'b0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      got[255 - k] = sdata_out;
      if (k == 15) sync = 1'b0;
      if (k == inj) begin stat_addr = ia; stat_data = id; stat_req = 1'b1; end
      else stat_req = 1'b0;
    end
    stat_req = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R2 line low after frame", {31'h0, sdata_out}, 32'h0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [255:0] got;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: idle line after reset
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check("R1 idle after reset", {31'h0, sdata_out}, 32'h0);
    end
    // First frame with nothing pending (R4, R8, R10)
    gpio_in = 16'h0000;
    run_frame(-1, 8'h0, 16'h0, got);
    compare("R1 first-frame", got, build_exp(2'd0, 1'b0, '0, '0, 1'b0, '0, '0, 16'h0), 2'd0, 1'b0);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      gpio_in  = V_GPIO[v];
      slot_sel = V_SEL[v];
      if (V_AVAL[v]) send_adc(V_L[v], V_R[v]);
      if (V_SREQ[v]) send_stat(V_ADDR[v], V_DATA[v]);
      run_frame(-1, 8'h0, 16'h0, got);
      compare($sformatf("vec%0d", v), got,
              build_exp(V_SEL[v], V_AVAL[v], V_L[v], V_R[v], V_SREQ[v], V_ADDR[v], V_DATA[v], V_GPIO[v]),
              V_SEL[v], V_AVAL[v]);
    end

    // R5: request in mid-frame is held for next frame, then dropped
    gpio_in = 16'h0F0F; slot_sel = 2'd0;
    run_frame(100, 8'h3C, 16'hBEEF, got);
    compare("R5 mid-frame req not early", got, build_exp(2'd0, 1'b0, '0, '0, 1'b0, '0, '0, 16'h0F0F), 2'd0, 1'b0);
    run_frame(-1, 8'h0, 16'h0, got);
    compare("R5 mid-frame req next frame", got, build_exp(2'd0, 1'b0, '0, '0, 1'b1, 8'h3C, 16'hBEEF, 16'h0F0F), 2'd0, 1'b0);
    run_frame(-1, 8'h0, 16'h0, got);
    compare("R5 sent once", got, build_exp(2'd0, 1'b0, '0, '0, 1'b0, '0, '0, 16'h0F0F), 2'd0, 1'b0);

    // R5: request on the frame-start edge
    run_frame(-2, 8'h5A, 16'hC3C3, got);
    compare("R5 start-edge req not early", got, build_exp(2'd0, 1'b0, '0, '0, 1'b0, '0, '0, 16'h0F0F), 2'd0, 1'b0);
    run_frame(-1, 8'h0, 16'h0, got);
    compare("R5 start-edge req next frame", got, build_exp(2'd0, 1'b0, '0, '0, 1'b1, 8'h5A, 16'hC3C3, 16'h0F0F), 2'd0, 1'b0);

    // R5: latest of two requests wins
    send_stat(8'h11, 16'h1111);
    send_stat(8'h22, 16'h2222);
    run_frame(-1, 8'h0, 16'h0, got);
    compare("R5 latest wins", got, build_exp(2'd0, 1'b0, '0, '0, 1'b1, 8'h22, 16'h2222, 16'h0F0F), 2'd0, 1'b0);

    // R7: sample pair sent once
    slot_sel = 2'd2;
    send_adc(20'hC0FFE, 20'h0BEAD);
    run_frame(-1, 8'h0, 16'h0, got);
    compare("R7 pair sent", got, build_exp(2'd2, 1'b1, 20'hC0FFE, 20'h0BEAD, 1'b0, '0, '0, 16'h0F0F), 2'd2, 1'b1);
    run_frame(-1, 8'h0, 16'h0, got);
    compare("R7 pair not repeated", got, build_exp(2'd2, 1'b0, '0, '0, 1'b0, '0, '0, 16'h0F0F), 2'd2, 1'b0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule